// File: doc/BRIEF.md
# Quad Hot-Swap Channel Controller

This block is the digital sequencing core of a four-channel hot-swap controller. Its inputs are flags that analog comparators have already digitised. Each rail has an undervoltage-lockout-clear flag, a power-good flag, an enable and two overcurrent flags: a slow one for long, moderate overloads and a fast one for severe overloads. From these flags the block drives three outputs per channel: a gate enable, a startup current-limit enable and a status flag.

A channel may power up only after these conditions hold:
- the supply has been continuously qualified for a lockout hold time;
- the channel's own power-good is high;
- the channel's own enable is high.

The channel then passes through a programmable startup window. In that window overcurrent only causes current limiting, never shutdown. Status rises when the window closes. After that, an overcurrent is a fault. The fault either latches the channel off until its enable is toggled, or it waits a retry delay and restarts. In grouped mode the four channels behave as one: a lost condition on any channel, or a fault on any channel, stops all four, and an enable toggle on any channel clears all four.

All flag inputs and the two mode selects pass through two-flop synchronisers. The startup-window value `su_cfg` is treated as static configuration and is not synchronised.

Each channel runs its own state machine with five states:
- **OFF**: gate off.
- **START**: gate on, current limit on.
- **RUN**: gate on, status on.
- **LATCHED**: gate off, waiting for an enable toggle.
- **RETRY**: gate off, timed wait before restart.

Transitions:
- **OFF→START**: the turn-on condition is met.
- **START→RUN**: the window timer reaches zero.
- **START/RUN→OFF**: the condition is lost.
- **RUN→LATCHED** or **RUN→RETRY**: overcurrent in RUN.
- **START/RUN→LATCHED/RETRY**: in grouped mode, another channel faults.
- **LATCHED→OFF**: an enable toggle clears the latch.
- **RETRY→START** or **RETRY→OFF**: the retry timer expires, going to START if the condition holds and to OFF otherwise.

If a fault and a lost condition arrive together, the fault wins.

Top module: `hsc_quad_ctrl`

## Requirements
- R1: Lockout qualification requires at least one `rail_uvlo_ok` bit to stay high for UVLO_TICKS = CLK_HZ·37.5 ms consecutive clocks; any gap restarts the count. When every other condition is already met, `ilim_en` rises on the (UVLO_TICKS+3)-th falling clock edge after the flag is driven.
- R2: In independent mode, channel i turns on only while qualification, `rail_pgood[i]` and `ch_on[i]` are all high. Dropping either of its own flags clears `gate_en[i]` by the third falling edge and leaves the other channels running.
- R3: The startup window keeps `ilim_en` high for exactly P clocks. P is taken from `su_cfg` as follows:
  - 0 gives the 9 ms default;
  - values below the 0.4 ms minimum are raised to that minimum;
  - values above the 50 ms maximum are lowered to that maximum.
- R4: `stat[i]` rises in the same cycle the window ends, provided no fault has occurred.
- R5: While in the startup window, both overcurrent flags are ignored: the channel reaches RUN with no fault.
- R6: In RUN, either overcurrent flag drops `stat` and `gate_en` by the third falling edge. With `latch_off`=1 the channel stays off after the flag clears.
- R7: A latched channel restarts only when its `ch_on` is seen low and then high. In independent mode, another channel's latch is unaffected by that toggle.
- R8: With `latch_off`=0, a fault holds `gate_en` low for exactly RETRY_TICKS clocks, then re-enters the startup window automatically.
- R9: With `grp_mode`=1, a fault on any channel, or the loss of any channel's power-good or enable, turns off all four channels.
- R10: With `grp_mode`=1, toggling any one `ch_on` clears the latch on all four channels.
- R11: In independent mode, a fault on one channel leaves the other channels' `stat` high.
- R12: During and right after reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| rail_uvlo_ok | input | NCH | per-rail lockout-clear flag |
| rail_pgood | input | NCH | per-channel input power-good |
| ch_on | input | NCH | per-channel enable |
| oc_slow | input | NCH | slow overcurrent flag |
| oc_fast | input | NCH | fast overcurrent flag |
| grp_mode | input | 1 | 1 = grouped, 0 = independent |
| latch_off | input | 1 | 1 = latch after fault, 0 = autoretry |
| su_cfg | input | SU_W | startup window in clocks; 0 selects the default |
| gate_en | output | NCH | gate drive enable |
| ilim_en | output | NCH | startup current-limit enable |
| stat | output | NCH | channel-good status |

## Verification
The hardest situation to reach is a latch that must survive while a neighbour's latch is cleared. The stimulus latches two channels in the same cycle, one on each overcurrent flag, toggles the enable of only one of them, and confirms that the other's gate stays low. Grouped-mode clearing is reached the same way, by faulting one channel and toggling the enable of a different one. The exact window, lockout and retry lengths are measured by counting clocks at the ports. A table sweeps the window setting across its default, both clamps and in-range values.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
    typedef enum logic [2:0] {
        CH_OFF,
        CH_START,
        CH_RUN,
        CH_LATCHED,
        CH_RETRY
    } ch_state_t;
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hsc_uvlo_qual.sv
module hsc_uvlo_qual #(
    parameter int NRAIL      = 4,
    parameter int HOLD_TICKS = 37500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NRAIL-1:0] rail_ok,
    output logic             qual
);
    localparam int CW = $clog2(HOLD_TICKS + 1);

    logic [CW-1:0] cnt;
    logic          any_ok;

    assign any_ok = |rail_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!any_ok) begin
            cnt <= '0;
        end else if (cnt != CW'(HOLD_TICKS)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = (cnt == CW'(HOLD_TICKS));

    // R1: qualification can only appear after a cycle with a rail above threshold
    p_qual_needs_rail_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual) |-> $past(any_ok));

    // R1: a gap in every rail drops qualification at the next edge
    p_gap_drops_qual_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ok |=> !qual);
endmodule

// File: rtl/hsc_chan_fsm.sv
module hsc_chan_fsm
    import hsc_pkg::*;
#(
    parameter int TW          = 16,
    parameter int RETRY_TICKS = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cond_ok,
    input  logic          oc_any,
    input  logic          ext_fault,
    input  logic          clr_req,
    input  logic          retry_en,
    input  logic [TW-1:0] period,
    output logic          fault_now,
    output logic          gate_en,
    output logic          ilim_en,
    output logic          stat
);
    ch_state_t     state, state_n;
    ch_state_t     fault_dst;
    logic [TW-1:0] timer;

    assign fault_now = (state == CH_RUN) && oc_any;
    assign fault_dst = retry_en ? CH_RETRY : CH_LATCHED;

    always_comb begin
        state_n = state;
        unique case (state)
            CH_OFF:     if (cond_ok) state_n = CH_START;
            CH_START: begin
                if (ext_fault)        state_n = fault_dst;
                else if (!cond_ok)    state_n = CH_OFF;
                else if (timer == '0) state_n = CH_RUN;
            end
            CH_RUN: begin
                if (fault_now || ext_fault) state_n = fault_dst;
                else if (!cond_ok)          state_n = CH_OFF;
            end
            CH_LATCHED: if (clr_req) state_n = CH_OFF;
            CH_RETRY:   if (timer == '0) state_n = cond_ok ? CH_START : CH_OFF;
            default:    state_n = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (state_n == CH_START && state != CH_START) begin
            timer <= period - 1'b1;
        end else if (state_n == CH_RETRY && state != CH_RETRY) begin
            timer <= TW'(RETRY_TICKS - 1);
        end else if (timer != '0) begin
            timer <= timer - 1'b1;
        end
    end

    always_comb begin
        gate_en = 1'b0;
        ilim_en = 1'b0;
        stat    = 1'b0;
        unique case (state)
            CH_START: begin
                gate_en = 1'b1;
                ilim_en = 1'b1;
            end
            CH_RUN: begin
                gate_en = 1'b1;
                stat    = 1'b1;
            end
            default: ;
        endcase
    end

    // R2: the window is entered only when the turn-on condition held
    p_start_needs_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_START && $past(state) != CH_START) |-> $past(cond_ok));

    // R7: a latched channel leaves its latch only on a clear request
    p_latch_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == CH_LATCHED && state != CH_LATCHED) |-> $past(clr_req));

    // R6: overcurrent while running always lands in a fault state
    p_run_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == CH_RUN && $past(oc_any))
            |-> (state == CH_LATCHED || state == CH_RETRY));

    // R5: overcurrent inside the window does not create a fault
    p_start_oc_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == CH_START && $past(oc_any) && $past(cond_ok) && !$past(ext_fault))
            |-> (state == CH_START || state == CH_RUN));
endmodule

// File: rtl/hsc_quad_ctrl.sv
module hsc_quad_ctrl #(
    parameter int NCH      = 4,
    parameter int CLK_HZ   = 1000000,
    parameter int RETRY_MS = 100,
    parameter int SU_W     = $clog2(CLK_HZ / 20 + 1) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  rail_uvlo_ok,
    input  logic [NCH-1:0]  rail_pgood,
    input  logic [NCH-1:0]  ch_on,
    input  logic [NCH-1:0]  oc_slow,
    input  logic [NCH-1:0]  oc_fast,
    input  logic            grp_mode,
    input  logic            latch_off,
    input  logic [SU_W-1:0] su_cfg,
    output logic [NCH-1:0]  gate_en,
    output logic [NCH-1:0]  ilim_en,
    output logic [NCH-1:0]  stat
);
    localparam int UVLO_TICKS  = CLK_HZ * 3 / 80;
    localparam int MAX_TICKS   = CLK_HZ / 20;
    localparam int MIN_RAW     = CLK_HZ / 2500;
    localparam int MIN_TICKS   = (MIN_RAW < 1) ? 1 : MIN_RAW;
    localparam int DEF_TICKS   = CLK_HZ * 9 / 1000;
    localparam int RETRY_TICKS = (CLK_HZ / 1000) * RETRY_MS;
    localparam int TOP_TICKS   = (MAX_TICKS > RETRY_TICKS) ? MAX_TICKS : RETRY_TICKS;
    localparam int TW          = $clog2(TOP_TICKS + 1);
    localparam int SW          = 5 * NCH + 2;

    logic [SW-1:0]  sync_d, sync_q;
    logic [NCH-1:0] uv_s, pg_s, on_s, slow_s, fast_s;
    logic           grp_s, latch_s;
    logic [NCH-1:0] on_prev, on_rise;
    logic [NCH-1:0] cond, fault_vec, clr;
    logic           qual, grp_cond, grp_fault;
    logic [TW-1:0]  su_eff;

    assign sync_d = {latch_off, grp_mode, oc_fast, oc_slow, ch_on, rail_pgood, rail_uvlo_ok};

    hsc_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_d),
        .q     (sync_q)
    );

    assign uv_s    = sync_q[0*NCH +: NCH];
    assign pg_s    = sync_q[1*NCH +: NCH];
    assign on_s    = sync_q[2*NCH +: NCH];
    assign slow_s  = sync_q[3*NCH +: NCH];
    assign fast_s  = sync_q[4*NCH +: NCH];
    assign grp_s   = sync_q[5*NCH];
    assign latch_s = sync_q[5*NCH + 1];

    hsc_uvlo_qual #(.NRAIL(NCH), .HOLD_TICKS(UVLO_TICKS)) u_uvlo (
        .clk     (clk),
        .rst_n   (rst_n),
        .rail_ok (uv_s),
        .qual    (qual)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) on_prev <= '0;
        else        on_prev <= on_s;
    end

    assign on_rise   = on_s & ~on_prev;
    assign grp_cond  = qual && (&(pg_s & on_s));
    assign grp_fault = grp_s && (|fault_vec);

    always_comb begin
        if (su_cfg == '0)
            su_eff = TW'(DEF_TICKS);
        else if (32'(su_cfg) < 32'(MIN_TICKS))
            su_eff = TW'(MIN_TICKS);
        else if (32'(su_cfg) > 32'(MAX_TICKS))
            su_eff = TW'(MAX_TICKS);
        else
            su_eff = TW'(su_cfg);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign cond[i] = grp_s ? grp_cond : (qual && pg_s[i] && on_s[i]);
        assign clr[i]  = grp_s ? (|on_rise) : on_rise[i];

        hsc_chan_fsm #(.TW(TW), .RETRY_TICKS(RETRY_TICKS)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .cond_ok   (cond[i]),
            .oc_any    (slow_s[i] | fast_s[i]),
            .ext_fault (grp_fault),
            .clr_req   (clr[i]),
            .retry_en  (!latch_s),
            .period    (su_eff),
            .fault_now (fault_vec[i]),
            .gate_en   (gate_en[i]),
            .ilim_en   (ilim_en[i]),
            .stat      (stat[i])
        );
    end

    // R9: in grouped mode one channel's fault leaves no channel reporting good
    p_grp_fault_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_s && |fault_vec) |=> (stat == '0));

    // R12: nothing drives a gate before qualification has ever been reached
    p_no_gate_unqualified_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!qual && $past(!qual) && ilim_en == '0 && stat == '0) |=> (ilim_en == '0));
endmodule

// File: tb/sim_hsc_quad_ctrl.sv
module sim_hsc_quad_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int CLK_HZ     = 10000;
    localparam int RETRY_MS   = 10;
    localparam int SU_W       = $clog2(CLK_HZ / 20 + 1) + 1;
    localparam int UVLO_T     = CLK_HZ * 3 / 80;
    localparam int RETRY_T    = (CLK_HZ / 1000) * RETRY_MS;
    localparam int NVEC       = 6;
    // window setting, expected window length (default 90, min 4, max 500)
    localparam int VTAB [NVEC][2] = '{'{0, 90}, '{2, 4}, '{4, 4}, '{30, 30}, '{500, 500}, '{600, 500}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  rail_uvlo_ok = '0, rail_pgood = '0, ch_on = '0, oc_slow = '0, oc_fast = '0;
    logic            grp_mode = 1'b0, latch_off = 1'b1;
    logic [SU_W-1:0] su_cfg = SU_W'(30);
    logic [NCH-1:0]  gate_en, ilim_en, stat;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hsc_quad_ctrl #(.NCH(NCH), .CLK_HZ(CLK_HZ), .RETRY_MS(RETRY_MS), .SU_W(SU_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rail_uvlo_ok(rail_uvlo_ok), .rail_pgood(rail_pgood),
        .ch_on(ch_on), .oc_slow(oc_slow), .oc_fast(oc_fast), .grp_mode(grp_mode),
        .latch_off(latch_off), .su_cfg(su_cfg), .gate_en(gate_en), .ilim_en(ilim_en), .stat(stat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ilim(input int ch, input int cap, output int k);
        k = 0;
        while (!ilim_en[ch] && k < cap) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic len_ilim(input int ch, input int cap, output int k);
        k = 0;
        while (ilim_en[ch] && k < cap) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int k;
        step(3);
        chk(gate_en == 0 && ilim_en == 0 && stat == 0, "R12 in reset", int'(gate_en), 0);
        rst_n = 1'b1;
        rail_pgood = '1;
        ch_on = '1;
        step(2);
        chk(gate_en == 0 && ilim_en == 0 && stat == 0, "R12 after reset", int'(gate_en), 0);

        // R1: a short rail pulse must not qualify, and the gap restarts the count
        rail_uvlo_ok = 4'b0001;
        step(200);
        rail_uvlo_ok = '0;
        step(10);
        chk(gate_en == 0, "R1 short pulse", int'(gate_en), 0);
        rail_uvlo_ok = 4'b0100;
        k = 0;
        while (!ilim_en[0] && k < 1000) begin
            @(negedge clk);
            k++;
        end
        chk(k == UVLO_T + 3, "R1 qualification delay", k, UVLO_T + 3);
        chk(ilim_en == 4'hF, "R2 all channels start", int'(ilim_en), 15);
        len_ilim(0, 1000, k);
        chk(k == 30, "R3 window 30", k, 30);
        chk(stat == 4'hF, "R4 status after window", int'(stat), 15);

        // R3 / R4: window setting sweep
        for (int v = 0; v < NVEC; v++) begin
            ch_on = '0;
            step(5);
            su_cfg = SU_W'(VTAB[v][0]);
            ch_on = '1;
            wait_ilim(0, 20, k);
            len_ilim(0, 1000, k);
            chk(k == VTAB[v][1], "R3 window sweep", k, VTAB[v][1]);
            chk(stat[0] == 1'b1, "R4 status at window end", int'(stat[0]), 1);
        end

        // R5: overcurrent inside the window is ignored
        su_cfg = SU_W'(30);
        ch_on[0] = 1'b0;
        step(4);
        ch_on[0] = 1'b1;
        step(6);
        chk(ilim_en[0] == 1'b1, "R5 in window", int'(ilim_en[0]), 1);
        oc_slow[0] = 1'b1;
        oc_fast[0] = 1'b1;
        step(10);
        oc_slow[0] = 1'b0;
        oc_fast[0] = 1'b0;
        step(40);
        chk(stat[0] == 1'b1, "R5 no fault from window overcurrent", int'(stat[0]), 1);

        // R6 / R11: latched faults on channels 1 (fast) and 2 (slow)
        oc_fast[1] = 1'b1;
        oc_slow[2] = 1'b1;
        step(3);
        chk(gate_en[1] == 0 && stat[1] == 0, "R6 fast fault off", int'(gate_en[1]), 0);
        chk(gate_en[2] == 0 && stat[2] == 0, "R6 slow fault off", int'(gate_en[2]), 0);
        chk(stat[0] == 1 && stat[3] == 1, "R11 others stay up", int'(stat), 9);
        oc_fast[1] = 1'b0;
        oc_slow[2] = 1'b0;
        step(150);
        chk(gate_en[2:1] == 2'b00, "R6 stays latched", int'(gate_en[2:1]), 0);

        // R7: toggle only channel 1
        ch_on[1] = 1'b0;
        step(3);
        ch_on[1] = 1'b1;
        step(4);
        chk(ilim_en[1] == 1'b1, "R7 toggled channel restarts", int'(ilim_en[1]), 1);
        chk(gate_en[2] == 1'b0, "R7 other latch kept", int'(gate_en[2]), 0);
        step(40);
        chk(stat[1] == 1'b1, "R7 restarted channel good", int'(stat[1]), 1);
        ch_on[2] = 1'b0;
        step(3);
        ch_on[2] = 1'b1;
        step(40);
        chk(stat[2] == 1'b1, "R7 channel 2 cleared", int'(stat[2]), 1);

        // R2: own power-good loss
        rail_pgood[3] = 1'b0;
        step(3);
        chk(gate_en[3] == 1'b0, "R2 power-good loss", int'(gate_en[3]), 0);
        chk(gate_en[0] == 1'b1, "R2 neighbour unaffected", int'(gate_en[0]), 1);
        rail_pgood[3] = 1'b1;
        step(40);
        chk(stat[3] == 1'b1, "R2 recovers", int'(stat[3]), 1);

        // R8: autoretry delay
        latch_off = 1'b0;
        step(4);
        oc_fast[0] = 1'b1;
        step(1);
        oc_fast[0] = 1'b0;
        k = 0;
        while (gate_en[0] && k < 6) begin
            @(negedge clk);
            k++;
        end
        k = 0;
        while (!gate_en[0] && k < 1000) begin
            @(negedge clk);
            k++;
        end
        chk(k == RETRY_T, "R8 retry delay", k, RETRY_T);
        chk(ilim_en[0] == 1'b1, "R8 window re-entered", int'(ilim_en[0]), 1);
        step(40);
        chk(stat[0] == 1'b1, "R8 good after retry", int'(stat[0]), 1);

        // R9 / R10: grouped mode
        grp_mode = 1'b1;
        latch_off = 1'b1;
        step(4);
        chk(stat == 4'hF, "R9 grouped steady", int'(stat), 15);
        oc_slow[3] = 1'b1;
        step(1);
        oc_slow[3] = 1'b0;
        step(2);
        chk(gate_en == 4'h0, "R9 grouped fault all off", int'(gate_en), 0);
        step(50);
        chk(gate_en == 4'h0, "R9 grouped stays latched", int'(gate_en), 0);
        ch_on[0] = 1'b0;
        step(3);
        ch_on[0] = 1'b1;
        step(4);
        chk(ilim_en == 4'hF, "R10 one toggle clears all", int'(ilim_en), 15);
        step(40);
        chk(stat == 4'hF, "R10 all good again", int'(stat), 15);
        rail_pgood[2] = 1'b0;
        step(3);
        chk(gate_en == 4'h0, "R9 grouped condition loss", int'(gate_en), 0);
        rail_pgood[2] = 1'b1;
        step(3);
        chk(ilim_en == 4'hF, "R9 grouped restart", int'(ilim_en), 15);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule